// File: doc/BRIEF.md
# Paired-Channel Lockstep Output Checker

This block sits between the compare stages of a group of timer channels and their external pins. The channels are grouped in adjacent pairs, and the two channels of a pair are expected to produce identical output flags in every cycle. When a channel has checking switched on and its flag differs from its partner's, the block latches a sticky fault for that channel. While the fault is held, the channel's output is driven to its inactive level.

The block also handles the rest of each channel's pin path. The polarity select is applied after any forcing. The output-enable bit is registered and decides whether the pin is driven. A per-channel input value is returned so that other channels can sample the pin: this is the driven value when the pin is an output, and the external level when it is not.

The channel count is set by `N_PAIRS`. Every state element is cleared by a synchronous active-high reset. All outputs are registered, except the sampled input value, which is a direct select between the registered drive and the external level.

Top module: `redund_out_chk`

## Requirements
- R1: Channel 2k is paired with channel 2k+1 (k = 0 .. N_PAIRS-1), and a channel is compared only against its own partner. A mismatch in one pair never affects the fault flag of a channel in another pair.
- R2: While a channel's check enable `rdn_en_i[c]` is 0, its fault flag `fault_o[c]` never changes from 0 to 1.
- R3: If `rdn_en_i[c]` is 1 and `oflag_i[c]` differs from the partner's `oflag_i` at a rising edge, `fault_o[c]` is 1 after that edge.
- R4: Once set, `fault_o[c]` stays 1 at every edge where `fault_clr_i[c]` is 0.
- R5: At an edge where `fault_clr_i[c]` is 1, `fault_o[c]` becomes 0, unless the R3 set condition also holds at that edge, in which case the set wins and `fault_o[c]` stays 1.
- R6: After an edge that leaves `fault_o[c]` at 1, `pin_o[c]` equals the `pol_i[c]` sampled at that edge. This is the inactive level 0 passed through the polarity select.
- R7: After an edge that leaves `fault_o[c]` at 0, `pin_o[c]` equals `oflag_i[c] XOR pol_i[c]` as sampled at that edge, and `pin_oe_o[c]` equals the `oe_i[c]` sampled at each edge.
- R8: `pin_val_o[c]` equals `pin_o[c]` while `pin_oe_o[c]` is 1, and equals `ext_pin_i[c]` while it is 0.
- R9: After an edge with `rst` at 1, all `fault_o`, `pin_o` and `pin_oe_o` bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| oflag_i | input | 2*N_PAIRS | Raw output flag from each channel's compare logic |
| rdn_en_i | input | 2*N_PAIRS | Per-channel enable for checking against the partner |
| oe_i | input | 2*N_PAIRS | Per-channel pin output enable |
| pol_i | input | 2*N_PAIRS | Per-channel output polarity invert |
| fault_clr_i | input | 2*N_PAIRS | Write-one-to-clear strobe for each fault flag |
| ext_pin_i | input | 2*N_PAIRS | External level seen on each pin when it is not driven |
| fault_o | output | 2*N_PAIRS | Sticky lockstep fault flag per channel |
| pin_o | output | 2*N_PAIRS | Registered pin drive value |
| pin_oe_o | output | 2*N_PAIRS | Registered pin output enable |
| pin_val_o | output | 2*N_PAIRS | Pin value available to other channels as an input |

## Verification
Matching flag patterns such as alternating pairs, all ones and all zeros are applied under each polarity setting. They confirm that the pin path inverts correctly and that agreement never raises a fault. A mismatch is then injected into one pair at a time, which separates correct pairing from a comparison against the wrong neighbour. The same mismatch is applied with checking enabled on only one side of each pair, which separates the per-channel enable from a shared pair enable. Holding a mismatch while the clear strobe is pulsed, and clearing after the flags agree again, distinguishes set-wins priority from clear-wins priority. Toggling output enable against a changing external level shows whether the sampled value follows the driven value or the outside level.

// File: rtl/redund_out_chk_pkg.sv
package redund_out_chk_pkg;

  // Index of the lockstep partner of a channel: pairs are (0,1), (2,3), ...
  function automatic int partner_of(input int ch);
    return ch ^ 1;
  endfunction

  // Registered pin state of one channel
  typedef struct packed {
    logic drv;
    logic oe;
  } pin_state_t;

endpackage

// File: rtl/rco_pair_cmp.sv
module rco_pair_cmp #(
  parameter int N_PAIRS = 3,
  localparam int NCH    = 2 * N_PAIRS
) (
  input  logic [NCH-1:0] oflag_i,
  output logic [NCH-1:0] mism_o
);
  import redund_out_chk_pkg::*;

  // One comparator per channel against its partner
  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    localparam int P = partner_of(c);
    assign mism_o[c] = oflag_i[c] ^ oflag_i[P];
  end

endmodule

// File: rtl/rco_fault_cell.sv
module rco_fault_cell (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic mism_i,
  input  logic clr_i,
  output logic fault_nxt_o,
  output logic fault_o
);
  logic fault_q;
  logic set_c;

  // Set has priority over the clear strobe
  always_comb begin
    set_c       = en_i & mism_i;
    fault_nxt_o = set_c | (fault_q & ~clr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= fault_nxt_o;
  end

  assign fault_o = fault_q;

endmodule

// File: rtl/rco_pin_cell.sv
module rco_pin_cell (
  input  logic clk,
  input  logic rst,
  input  logic oflag_i,
  input  logic fault_nxt_i,
  input  logic pol_i,
  input  logic oe_i,
  input  logic ext_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic pin_val_o
);
  import redund_out_chk_pkg::*;

  pin_state_t st_q;
  pin_state_t st_d;

  // Force to inactive (0) before polarity, then invert if selected
  always_comb begin
    st_d.drv = (oflag_i & ~fault_nxt_i) ^ pol_i;
    st_d.oe  = oe_i;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign pin_o     = st_q.drv;
  assign pin_oe_o  = st_q.oe;
  // A driven pin reads back its own drive, otherwise the outside level
  assign pin_val_o = st_q.oe ? st_q.drv : ext_i;

endmodule

// File: rtl/redund_out_chk.sv
module redund_out_chk #(
  parameter int N_PAIRS = 3,
  localparam int NCH    = 2 * N_PAIRS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] oflag_i,
  input  logic [NCH-1:0] rdn_en_i,
  input  logic [NCH-1:0] oe_i,
  input  logic [NCH-1:0] pol_i,
  input  logic [NCH-1:0] fault_clr_i,
  input  logic [NCH-1:0] ext_pin_i,
  output logic [NCH-1:0] fault_o,
  output logic [NCH-1:0] pin_o,
  output logic [NCH-1:0] pin_oe_o,
  output logic [NCH-1:0] pin_val_o
);

  logic [NCH-1:0] mism;
  logic [NCH-1:0] fault_nxt;

  rco_pair_cmp #(.N_PAIRS(N_PAIRS)) i_cmp (
    .oflag_i (oflag_i),
    .mism_o  (mism)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rco_fault_cell i_fault (
      .clk         (clk),
      .rst         (rst),
      .en_i        (rdn_en_i[c]),
      .mism_i      (mism[c]),
      .clr_i       (fault_clr_i[c]),
      .fault_nxt_o (fault_nxt[c]),
      .fault_o     (fault_o[c])
    );

    rco_pin_cell i_pin (
      .clk         (clk),
      .rst         (rst),
      .oflag_i     (oflag_i[c]),
      .fault_nxt_i (fault_nxt[c]),
      .pol_i       (pol_i[c]),
      .oe_i        (oe_i[c]),
      .ext_i       (ext_pin_i[c]),
      .pin_o       (pin_o[c]),
      .pin_oe_o    (pin_oe_o[c]),
      .pin_val_o   (pin_val_o[c])
    );
  end

endmodule

// File: rtl/redund_out_chk_sva.sv
module redund_out_chk_sva #(
  parameter int N_PAIRS = 3,
  localparam int NCH    = 2 * N_PAIRS
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] oflag_i,
  input logic [NCH-1:0] rdn_en_i,
  input logic [NCH-1:0] oe_i,
  input logic [NCH-1:0] pol_i,
  input logic [NCH-1:0] fault_clr_i,
  input logic [NCH-1:0] ext_pin_i,
  input logic [NCH-1:0] fault_o,
  input logic [NCH-1:0] pin_o,
  input logic [NCH-1:0] pin_oe_o,
  input logic [NCH-1:0] pin_val_o
);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (fault_o == '0 && pin_o == '0 && pin_oe_o == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam int P = c ^ 1;

    p_no_set_disabled_r2: assert property (@(posedge clk) disable iff (rst)
      (!rdn_en_i[c] && !fault_o[c]) |=> !fault_o[c]);

    p_mismatch_sets_r3: assert property (@(posedge clk) disable iff (rst)
      (rdn_en_i[c] && (oflag_i[c] != oflag_i[P])) |=> fault_o[c]);

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
      (fault_o[c] && !fault_clr_i[c]) |=> fault_o[c]);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (fault_clr_i[c] && !(rdn_en_i[c] && (oflag_i[c] != oflag_i[P])))
        |=> !fault_o[c]);

    p_forced_r6: assert property (@(posedge clk) disable iff (rst)
      (rdn_en_i[c] && (oflag_i[c] != oflag_i[P])) |=> (pin_o[c] == $past(pol_i[c])));

    p_oe_follow_r7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (pin_oe_o[c] == $past(oe_i[c])));

    p_loopback_r8: assert property (@(posedge clk) disable iff (rst)
      pin_oe_o[c] |-> (pin_val_o[c] == pin_o[c]));
  end

endmodule

bind redund_out_chk redund_out_chk_sva #(.N_PAIRS(N_PAIRS)) i_sva (
  .clk         (clk),
  .rst         (rst),
  .oflag_i     (oflag_i),
  .rdn_en_i    (rdn_en_i),
  .oe_i        (oe_i),
  .pol_i       (pol_i),
  .fault_clr_i (fault_clr_i),
  .ext_pin_i   (ext_pin_i),
  .fault_o     (fault_o),
  .pin_o       (pin_o),
  .pin_oe_o    (pin_oe_o),
  .pin_val_o   (pin_val_o)
);

// File: tb/test_redund_out_chk.sv
`timescale 1ns/1ps
module test_redund_out_chk;
  localparam int NP = 3;
  localparam int W  = 2 * NP;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] oflag, rdn_en, oe, pol, clr, ext;
  logic [W-1:0] fault, pin, pin_oe, pin_val;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  redund_out_chk #(.N_PAIRS(NP)) i_redund_out_chk (
    .clk(clk), .rst(rst), .oflag_i(oflag), .rdn_en_i(rdn_en), .oe_i(oe),
    .pol_i(pol), .fault_clr_i(clr), .ext_pin_i(ext), .fault_o(fault),
    .pin_o(pin), .pin_oe_o(pin_oe), .pin_val_o(pin_val)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Apply inputs at the falling edge, sample 1 ns after the next rising edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [W-1:0] f, input logic [W-1:0] en,
                       input logic [W-1:0] o, input logic [W-1:0] p,
                       input logic [W-1:0] c);
    @(negedge clk);
    oflag = f; rdn_en = en; oe = o; pol = p; clr = c;
  endtask

  task automatic clear_all();
    drive('0, '1, '1, '0, '1);
    step();
    drive('0, '1, '1, '0, '0);
  endtask

  task automatic t_reset();
    rst = 1'b1; oflag = '1; rdn_en = '1; oe = '1; pol = '1; clr = '0; ext = 6'b101100;
    step(); step();
    check("R9 fault after reset", fault, '0);
    check("R9 pin after reset", pin, '0);
    check("R9 oe after reset", pin_oe, '0);
    check("R8 undriven pin reads external", pin_val, ext);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_match();
    logic [W-1:0] pats [3] = '{6'b110011, 6'b111111, 6'b001100};
    logic [W-1:0] pols [3] = '{6'b000000, 6'b111111, 6'b010101};
    clear_all();
    foreach (pats[i]) foreach (pols[j]) begin
      drive(pats[i], '1, '1, pols[j], '0);
      step();
      check("R7 no fault on matching pairs", fault, '0);
      check("R7 pin equals flag xor polarity", pin, pats[i] ^ pols[j]);
      check("R8 driven pin loops back", pin_val, pats[i] ^ pols[j]);
    end
  endtask

  task automatic t_mismatch_per_pair();
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 2; k++) begin
        logic [W-1:0] pv  = (k == 0) ? '0 : '1;
        logic [W-1:0] pm  = 6'b000011 << (2 * p);
        logic [W-1:0] inj = 6'b000001 << (2 * p);
        clear_all();
        drive(inj, '1, '1, pv, '0);
        step();
        check("R1 R3 only the mismatching pair faults", fault, pm);
        check("R6 faulted pair forced to inactive level", pin, (inj & ~pm) ^ pv);
        drive('0, '1, '1, pv, '0);
        step();
        check("R4 fault holds after flags agree", fault, pm);
        drive(6'b111111, '1, '1, pv, '0);
        step();
        check("R6 forced level while flags agree", pin, (6'b111111 & ~pm) ^ pv);
        drive(6'b111111, '1, '1, pv, pm);
        step();
        check("R5 clear with agreeing flags", fault, '0);
        check("R7 pin released after clear", pin, 6'b111111 ^ pv);
      end
    end
  endtask

  task automatic t_disabled();
    clear_all();
    drive(6'b010101, 6'b010101, '1, '0, '0);
    step();
    check("R2 disabled channels stay clear", fault, 6'b010101);
    step();
    check("R2 disabled channels stay clear over time", fault, 6'b010101);
    check("R2 R7 disabled channel pin follows flag", pin & 6'b101010, 6'b000000);
    drive(6'b101010, 6'b000000, '1, '0, '0);
    step();
    check("R2 R4 all disabled, held faults remain", fault, 6'b010101);
  endtask

  task automatic t_clr_vs_set();
    clear_all();
    drive(6'b100110, '1, '1, '0, '0);
    step();
    check("R3 all pairs mismatch", fault, '1);
    drive(6'b100110, '1, '1, '0, '1);
    step();
    check("R5 set wins over clear", fault, '1);
    drive(6'b100110, '1, '1, '0, 6'b000011);
    step();
    check("R5 still wins on partial clear", fault, '1);
    drive(6'b100111, '1, '1, '0, 6'b000011);
    step();
    check("R5 clear of agreeing pair only", fault, 6'b111100);
  endtask

  task automatic t_ext();
    drive('1, '0, 6'b000111, '0, '1);
    ext = 6'b011010;
    step();
    check("R7 oe registered", pin_oe, 6'b000111);
    check("R8 mix of driven and external", pin_val, {ext[5:3], 3'b111});
    @(negedge clk); ext = 6'b100101;
    #1;
    check("R8 external change seen on undriven pins", pin_val, {3'b100, 3'b111});
    drive('1, '0, '0, '0, '0);
    step();
    check("R8 all undriven", pin_val, ext);
  endtask

  initial begin
    #100us;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_match();
    t_mismatch_per_pair();
    t_disabled();
    t_clr_vs_set();
    t_ext();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule